// File: doc/BRIEF.md
# Gated SD Card Clock Generator

This block produces the clock that an SD/MMC host drives onto the card, derived from a faster reference clock. A control word written through a simple write strobe sets three things: an internal enable that starts the divider, a card enable that lets the divided clock out, and an integer divide value. The same word reads back on `ctrl_o`, with a live clock-stable flag added.

A change of divide value, or of the internal enable, is never applied on the fly. A small sequencer first gates the card clock off at a low phase, then loads the new divider, waits until the divided clock has run two whole periods, and only then opens the gate again. A write that arrives during such a change is held and applied once the change is done. One sequencer covers the very slow start-up rate, the identification rate and the fast data rate chosen after reading the card's data.

Top module: `sd_card_clkgen`

## Requirements
- R1: Whenever `stable_o` is low, `card_clk_o` is low. A new divide value only takes effect after the gate has closed.
- R2: The control word has internal enable at bit 0, card enable at bit 2 and the divide value at bits 6 up to 6+DIV_W-1. A write that keeps both the divide value and the internal enable unchanged starts no change sequence: `busy_o` stays low, and only the card enable takes effect.
- R3: After a change, the card clock is opened again only once `stable_o` has been seen high.
- R4: When a new divider N is loaded while the internal enable is on, `stable_o` goes low for exactly 2*max(N,1) reference cycles, which is two full output periods.
- R5: A divide value N of at least 2 gives a card clock period of N reference cycles, high for floor(N/2) of them. A value of 0 or 1 passes the reference clock through.
- R6: Every high pulse on `card_clk_o` is full width, including the first pulse after the gate opens and the last pulse before it closes.
- R7: With the internal enable at 0, `card_clk_o` stays low and `stable_o` stays 0, whatever the card enable is.
- R8: A write during a change is held and applied after the change completes. When several writes arrive, only the last one is kept; earlier held writes are never loaded.
- R9: `busy_o` is high from the cycle after a write that starts a change until the gate has settled. `ctrl_o` returns the written fields at their write positions, with `stable_o` at bit 1.
- R10: Divide values up to 2^DIV_W-1 work, which covers a start-up rate of about 80 kHz (for example N=1200) as well as about 400 kHz (N=240).
- R11: After reset, `card_clk_o`, `busy_o` and `stable_o` are 0 and `ctrl_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Write strobe for the control word |
| ctrl_wdata_i | input | 32 | Control word to write |
| ctrl_o | output | 32 | Control word readback, with the stable flag at bit 1 |
| card_clk_o | output | 1 | Gated, divided clock to the card |
| stable_o | output | 1 | The divided internal clock has settled |
| busy_o | output | 1 | A change sequence is in progress |

## Verification
A wrong counter or load state in the divider shows up within one output period, as a period or high width that does not match the written divide value. It also shows up within 2N cycles of a change, as a low time of `stable_o` that does not match 2*max(N,1). A sequencer that opens the gate too early is seen on the very next sample, as a card clock edge while `stable_o` is low. A pending write that is lost or loaded twice changes the number of falling edges on `stable_o`, and this is visible as soon as `busy_o` settles.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int IEN_BIT = 0;
  localparam int STB_BIT = 1;
  localparam int CEN_BIT = 2;
  localparam int DIV_LSB = 6;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_GATE_OFF,
    SEQ_LOAD,
    SEQ_WAIT,
    SEQ_GATE_ON
  } seq_state_e;
endpackage

// File: rtl/sdclk_div_core.sv
module sdclk_div_core #(
  parameter int DIV_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             div_clk_o,
  output logic             bypass_o,
  output logic             stable_o,
  output logic             run_o,
  output logic [DIV_W-1:0] div_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] div_q, cnt_q, cnt_d, last_cnt, hi_cnt;
  logic             run_q, clk_q, wrap, first_q, stb_q;

  assign bypass_o = (div_q <= ONE);
  assign last_cnt = bypass_o ? '0 : div_q - ONE;
  assign hi_cnt   = div_q >> 1;
  assign wrap     = (cnt_q == last_cnt);
  assign cnt_d    = wrap ? '0 : cnt_q + ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      run_q   <= 1'b0;
      cnt_q   <= '0;
      clk_q   <= 1'b0;
      first_q <= 1'b0;
      stb_q   <= 1'b0;
    end else if (load_i) begin
      // restart phase: new period begins with its high half
      div_q   <= div_i;
      run_q   <= run_i;
      cnt_q   <= '0;
      clk_q   <= run_i && (div_i > ONE);
      first_q <= 1'b0;
      stb_q   <= 1'b0;
    end else if (!run_q) begin
      cnt_q   <= '0;
      clk_q   <= 1'b0;
      first_q <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= (cnt_d < hi_cnt);
      if (wrap) begin
        first_q <= 1'b1;
        if (first_q) stb_q <= 1'b1;
      end
    end
  end

  assign div_clk_o = clk_q;
  assign stable_o  = stb_q;
  assign run_o     = run_q;
  assign div_o     = div_q;
endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic div_clk_i,
  input  logic bypass_i,
  output logic gate_o,
  output logic card_clk_o
);
  logic gate_q;

  // updates only while the selected clock is low: no runt pulses
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         gate_q <= 1'b0;
    else if (!div_clk_i) gate_q <= en_i;
  end

  assign gate_o     = gate_q;
  assign card_clk_o = gate_q & (bypass_i ? clk_i : div_clk_i);
endmodule

// File: rtl/sdclk_seq.sv
module sdclk_seq
  import sdclk_pkg::*;
#(
  parameter int DIV_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             wr_ien_i,
  input  logic             wr_cen_i,
  input  logic [DIV_W-1:0] wr_div_i,
  input  logic             gate_q_i,
  input  logic             stable_i,
  input  logic             run_act_i,
  input  logic [DIV_W-1:0] div_act_i,
  output logic             load_o,
  output logic             busy_o,
  output logic             gate_en_o,
  output logic             ien_o,
  output logic             cen_o,
  output logic [DIV_W-1:0] div_o
);
  typedef struct packed {
    logic             ien;
    logic             cen;
    logic [DIV_W-1:0] div;
  } cfg_t;

  seq_state_e state_q, state_d;
  cfg_t       cur_q, pend_q, wr_cfg, take_cfg;
  logic       pend_v_q, take, launch, idle;

  assign wr_cfg   = '{ien: wr_ien_i, cen: wr_cen_i, div: wr_div_i};
  assign idle     = (state_q == SEQ_IDLE);
  assign take     = idle && (pend_v_q || we_i);
  assign take_cfg = pend_v_q ? pend_q : wr_cfg;
  assign launch   = take && ((take_cfg.div != div_act_i) || (take_cfg.ien != run_act_i));

  assign gate_en_o = cur_q.cen && cur_q.ien && stable_i &&
                     (idle || (state_q == SEQ_GATE_ON));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:     if (launch) state_d = SEQ_GATE_OFF;
      SEQ_GATE_OFF: if (!gate_q_i) state_d = SEQ_LOAD;
      SEQ_LOAD:     state_d = SEQ_WAIT;
      SEQ_WAIT:     if (stable_i || !cur_q.ien) state_d = SEQ_GATE_ON;
      SEQ_GATE_ON:  if (gate_q_i == gate_en_o) state_d = SEQ_IDLE;
      default:      state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      cur_q    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take) cur_q <= take_cfg;
      if (!idle) begin
        if (we_i) begin
          pend_q   <= wr_cfg;
          pend_v_q <= 1'b1;
        end
      end else if (pend_v_q) begin
        // held write consumed; a same-cycle write becomes the new held one
        pend_v_q <= we_i;
        if (we_i) pend_q <= wr_cfg;
      end
    end
  end

  assign load_o = (state_q == SEQ_LOAD);
  assign busy_o = !idle;
  assign ien_o  = cur_q.ien;
  assign cen_o  = cur_q.cen;
  assign div_o  = cur_q.div;
endmodule

// File: rtl/sd_card_clkgen.sv
module sd_card_clkgen
  import sdclk_pkg::*;
#(
  parameter int DIV_W = 11
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_we_i,
  input  logic [31:0] ctrl_wdata_i,
  output logic [31:0] ctrl_o,
  output logic        card_clk_o,
  output logic        stable_o,
  output logic        busy_o
);
  localparam logic [31:0] DIV_MASK  = ((32'd1 << DIV_W) - 32'd1) << DIV_LSB;
  localparam logic [31:0] USED_MASK = DIV_MASK | (32'd1 << IEN_BIT) | (32'd1 << CEN_BIT);

  logic             load, gate_en, gate_q, div_clk, bypass, run_act;
  logic             req_ien, req_cen;
  logic [DIV_W-1:0] req_div, div_act;
  logic             unused_wbits;

  assign unused_wbits = |(ctrl_wdata_i & ~USED_MASK);

  sdclk_seq #(.DIV_W(DIV_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctrl_we_i),
    .wr_ien_i  (ctrl_wdata_i[IEN_BIT]),
    .wr_cen_i  (ctrl_wdata_i[CEN_BIT]),
    .wr_div_i  (ctrl_wdata_i[DIV_LSB +: DIV_W]),
    .gate_q_i  (gate_q),
    .stable_i  (stable_o),
    .run_act_i (run_act),
    .div_act_i (div_act),
    .load_o    (load),
    .busy_o    (busy_o),
    .gate_en_o (gate_en),
    .ien_o     (req_ien),
    .cen_o     (req_cen),
    .div_o     (req_div)
  );

  sdclk_div_core #(.DIV_W(DIV_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .run_i     (req_ien),
    .div_i     (req_div),
    .div_clk_o (div_clk),
    .bypass_o  (bypass),
    .stable_o  (stable_o),
    .run_o     (run_act),
    .div_o     (div_act)
  );

  sdclk_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (gate_en),
    .div_clk_i  (div_clk),
    .bypass_i   (bypass),
    .gate_o     (gate_q),
    .card_clk_o (card_clk_o)
  );

  always_comb begin
    ctrl_o                   = '0;
    ctrl_o[IEN_BIT]          = req_ien;
    ctrl_o[STB_BIT]          = stable_o;
    ctrl_o[CEN_BIT]          = req_cen;
    ctrl_o[DIV_LSB +: DIV_W] = req_div;
  end
endmodule

// File: rtl/sd_card_clkgen_chk.sv
module sd_card_clkgen_chk #(
  parameter int DIV_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load,
  input logic             gate_q,
  input logic             div_clk,
  input logic             stable_o,
  input logic             run_act,
  input logic [DIV_W-1:0] div_act
);
  AST_GATE_SAFE_PHASE: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !$stable(gate_q) |-> !$past(div_clk)) else $error("gate moved while clock high"); // R6

  AST_GATE_OFF_AT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |-> !gate_q) else $error("divider loaded with gate open"); // R1

  AST_DIV_ONLY_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(div_act)) else $error("divider changed outside sequence"); // R2

  AST_STABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> !stable_o) else $error("stable not cleared on load"); // R4

  AST_GATE_NEEDS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_q |-> stable_o) else $error("gate open without stable clock"); // R3

  AST_NO_CLK_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_act |-> !gate_q) else $error("gate open with divider stopped"); // R7
endmodule

bind sd_card_clkgen sd_card_clkgen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load     (load),
  .gate_q   (gate_q),
  .div_clk  (div_clk),
  .stable_o (stable_o),
  .run_act  (run_act),
  .div_act  (div_act)
);

// File: tb/sd_card_clkgen_tb_top.sv
module sd_card_clkgen_tb_top;
  localparam int DIV_W = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] ctrl;
  logic        card_clk, stable, busy;

  always #4 clk = ~clk;

  sd_card_clkgen #(.DIV_W(DIV_W)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ctrl_we_i    (we),
    .ctrl_wdata_i (wdata),
    .ctrl_o       (ctrl),
    .card_clk_o   (card_clk),
    .stable_o     (stable),
    .busy_o       (busy)
  );

  int errors = 0, checks = 0, cycles = 0;
  int bench_div = 0, active_div = 0;
  bit hi_prev = 1'b0, stb_prev = 1'b0;
  int hi_run = 0, pulse_exp = 0, bad_pulses = 0, rises = 0, unsafe = 0;
  int stb_run = 0, stb_last = 0, stb_falls = 0;
  bit cur_ien = 1'b0, cur_cen = 1'b0;
  int cur_div = 0;

  function automatic int hi_len(int n);
    return (n <= 1) ? 1 : 2 * (n / 2);
  endfunction

  function automatic logic [31:0] word(bit ien, bit cen, int div);
    return (32'(div) << 6) | (32'(cen) << 2) | 32'(ien);
  endfunction

  task automatic sample_clk();
    if (card_clk && !hi_prev) begin
      rises++;
      hi_run = 1;
      pulse_exp = hi_len(active_div);
    end else if (card_clk) begin
      hi_run++;
    end else if (hi_prev && hi_run != pulse_exp) begin
      bad_pulses++;
    end
    if (card_clk && !stable) unsafe++;
    hi_prev = card_clk;
  endtask

  always @(posedge clk) begin
    #2;
    if (!stable) begin
      stb_run++;
      active_div = bench_div;
    end else if (!stb_prev) begin
      stb_last = stb_run;
      stb_run = 0;
    end
    if (stb_prev && !stable) stb_falls++;
    stb_prev = stable;
    sample_clk();
    #4;
    sample_clk();
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      finish_run();
    end
  end

  task automatic chk_eq(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 4) begin
      @(posedge clk);
      #3;
      if (busy) q = 0;
      else q++;
    end
  endtask

  task automatic cfg(bit ien, bit cen, int div, string tag);
    bit launch  = (div != cur_div) || (ien != cur_ien);
    bit chk_stb = launch && ien && cur_ien;
    int neff    = (div <= 1) ? 1 : div;
    int r0;
    int bad0    = bad_pulses;
    int uns0    = unsafe;
    @(negedge clk); #1;
    we = 1'b1;
    wdata = word(ien, cen, div);
    bench_div = div;
    @(negedge clk); #1;
    we = 1'b0;
    if (launch) chk_eq({tag, " R9 busy after change write"}, busy, 1);
    else        chk_eq({tag, " R2 busy after enable-only write"}, busy, 0);
    wait_idle();
    cur_div = div; cur_ien = ien; cur_cen = cen;
    if (chk_stb) chk_eq({tag, " R4 stable low cycles"}, stb_last, 2 * neff);
    chk_eq({tag, " R7 stable level"}, stable, ien);
    chk_eq({tag, " R9 readback"}, ctrl, word(ien, cen, div) | (32'(ien) << 1));
    r0 = rises;
    repeat (20 * neff) @(posedge clk);
    #3;
    chk_eq({tag, " R5 rises in 20 periods"}, rises - r0, (ien && cen) ? 20 : 0);
    chk_eq({tag, " R6 short pulses"}, bad_pulses - bad0, 0);
    chk_eq({tag, " R1 R3 clock while unstable"}, unsafe - uns0, 0);
  endtask

  initial begin
    int f0, r0;
    void'($urandom(32'h5d1c_0a77));
    repeat (3) @(posedge clk);
    #1;
    chk_eq("R11 card clock in reset", card_clk, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    chk_eq("R11 card clock after reset", card_clk, 0);
    chk_eq("R11 busy after reset", busy, 0);
    chk_eq("R11 stable after reset", stable, 0);
    chk_eq("R11 readback after reset", ctrl, 0);
    chk_eq("R11 no edges after reset", rises, 0);

    cfg(1, 1, 1200, "R10 slow");
    cfg(1, 1, 240, "R10 ident");
    cfg(1, 1, 0, "R5 bypass0");
    cfg(1, 1, 1, "R5 bypass1");
    cfg(1, 1, 2, "R5 div2");
    cfg(1, 1, 3, "R5 div3");
    cfg(1, 0, 3, "R2 gate off");
    cfg(1, 1, 3, "R2 gate on");
    cfg(0, 1, 3, "R7 stop");
    cfg(0, 1, 6, "R7 stopped change");
    cfg(1, 1, 6, "R7 restart");
    cfg(1, 1, 3, "R8 setup");

    // R8: three writes back to back; the middle one must never load
    f0 = stb_falls;
    @(negedge clk); #1;
    we = 1'b1; wdata = word(1, 0, 7); bench_div = 7;
    @(negedge clk); #1;
    wdata = word(1, 1, 9); bench_div = 9;
    @(negedge clk); #1;
    wdata = word(1, 1, 5); bench_div = 5;
    @(negedge clk); #1;
    we = 1'b0;
    wait_idle();
    cur_div = 5; cur_ien = 1'b1; cur_cen = 1'b1;
    chk_eq("R8 loads performed", stb_falls - f0, 2);
    chk_eq("R8 final readback", ctrl, word(1, 1, 5) | 32'h2);
    r0 = rises;
    repeat (100) @(posedge clk);
    #3;
    chk_eq("R8 R5 rises with last held value", rises - r0, 20);

    for (int i = 0; i < 10; i++) begin
      bit rien = ($urandom_range(0, 3) != 0);
      bit rcen = ($urandom_range(0, 3) != 0);
      int rdiv = $urandom_range(0, 20);
      cfg(rien, rcen, rdiv, "rand");
    end

    chk_eq("R6 total short pulses", bad_pulses, 0);
    finish_run();
  end
endmodule